// File: doc/BRIEF.md
# LIN Header Handler

This block adds LIN header processing next to a UART-style serial engine. As bus master it drives a break on the transmit line when asked to. As a slave it watches the receive line and runs each header through four stages. It spots the long dominant break and checks the recessive delimiter that follows. It times the 0x55 synch byte and retunes its own baud divider from that timing. It then samples the protected identifier and checks its two parity bits. A header that passes every step gives one valid-header pulse, with the identifier held on an output.

All timing counts ticks of an oversampling clock enable, `tick_en`. The divider register holds the number of ticks in one bit and can be read and written. The block reports problems as one-cycle error pulses: break seen, delimiter too short, synch outside tolerance, and identifier parity wrong. Software or a surrounding UART reacts to these pulses. The data field and checksum after the header are handled elsewhere.

Top module: `lin_header_top`

## Requirements
- R1: With `master_mode` high and no break in progress, a `brk_req` pulse drives `tx_o` low for exactly 13 bit times (13 × divider ticks), starting on the next clock, and `tx_busy_o` is high for that time. A `brk_req` while a break is in progress, or while `master_mode` is low, has no effect.
- R2: `brk_det_o` pulses once when `rx_i` has been low for 11 × divider consecutive ticks. A low run one tick shorter gives no pulse. Detection works in both modes.
- R3: In slave mode, after a break, `rx_i` must stay high for at least one bit time (divider ticks). If it goes low sooner, `err_delim_o` pulses and the header is dropped.
- R4: The synch measurement counts the ticks between the first and the fifth falling edge of the synch byte. The measured divider is that count plus 4, shifted right by 3, which is the count divided by 8 rounded half up.
- R5: The measured divider is accepted only if 17 × div ≤ 20 × measured ≤ 23 × div, where div is the programmed divider (±15 %). A measurement that is accepted replaces the divider. A measurement that is rejected pulses `err_sync_o`, leaves the divider as it was, and ends the header.
- R6: The identifier byte is sampled LSB first. The first sample is taken 1.5 bit times after its start-bit falling edge, and each later sample one bit time after the one before, using the divider just measured.
- R7: The identifier parity is checked with bit 6 = b0^b1^b2^b4 and bit 7 = NOT(b1^b3^b4^b5). On a mismatch `err_parity_o` pulses and there is no valid-header pulse.
- R8: Each header that passes every check gives exactly one `hdr_valid_o` pulse, and at that moment `pid_o` holds the received byte. The valid-header pulse and the three error pulses never occur in the same cycle.
- R9: A new break during a header abandons the header in progress. The abandoned header gives no valid-header or error pulse, and the next header is handled normally.
- R10: `div_o` resets to the parameter `DIV_RST`. A write through `div_wr_en`/`div_wr_data` shows on `div_o` the next cycle and takes priority over a synch update in the same cycle.
- R11: All bit timing advances only on cycles where `tick_en` is high.
- R12: While `master_mode` is high no header is processed, so there is no valid-header pulse, but break detection still reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oversampling clock enable |
| rx_i | input | 1 | Serial receive line (already synchronised) |
| tx_o | output | 1 | Serial transmit line, low during a generated break |
| master_mode | input | 1 | 1 = master (break generation), 0 = slave (header processing) |
| brk_req | input | 1 | Request to send a break |
| div_wr_en | input | 1 | Divider write strobe |
| div_wr_data | input | DIV_W | Divider value to write |
| div_o | output | DIV_W | Current divider, in ticks per bit |
| tx_busy_o | output | 1 | A break is being transmitted |
| brk_det_o | output | 1 | Break detected pulse |
| hdr_valid_o | output | 1 | Valid header pulse |
| pid_o | output | 8 | Last valid protected identifier |
| err_delim_o | output | 1 | Delimiter too short pulse |
| err_sync_o | output | 1 | Synch out of tolerance pulse |
| err_parity_o | output | 1 | Identifier parity mismatch pulse |

## Verification
The bench builds the block with DIV_W = 8 and DIV_RST = 16. At that size a break threshold is 176 cycles and a whole header takes about 600 cycles. This makes it possible to sweep the synch bit period from 12 to 20 ticks, covering both sides of the ±15 % window, and to send all 64 identifiers with both correct and corrupted parity. The small divider also makes the edge cases exact and short: a run of 175 against 176 low ticks, a delimiter of 15 against 16 ticks, a synch count that rounds down against one that rounds up, and master breaks with the enable present every cycle or every other cycle.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELIM,
        ST_SYNC_WAIT,
        ST_SYNC_MEAS,
        ST_STOP_WAIT,
        ST_PID_WAIT,
        ST_PID_RX
    } hdr_st_e;

    // tolerance window expressed as a fraction over TOL_DEN
    localparam int TOL_DEN = 20;
    localparam int TOL_LO  = 17;
    localparam int TOL_HI  = 23;

    // synch byte spans eight bit times between first and fifth fall
    localparam int SYNC_SHIFT = 3;

    function automatic logic [1:0] id_parity(input logic [5:0] id);
        return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4]};
    endfunction

endpackage

// File: rtl/lin_break_gen.sv
module lin_break_gen #(
    parameter int DIV_W = 16,
    parameter int CNT_W = DIV_W + 4,
    parameter int BITS  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             enable,
    input  logic             req,
    input  logic [DIV_W-1:0] div,
    output logic             tx_o,
    output logic             busy_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } gen_reg_t;

    gen_reg_t q, d;

    always_comb begin
        d = q;
        if (q.cnt != '0) begin
            if (tick_en) d.cnt = q.cnt - CNT_W'(1);
        end else if (req && enable) begin
            d.cnt = CNT_W'(BITS) * CNT_W'(div);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.cnt != '0);
    assign tx_o   = (q.cnt == '0);

endmodule

// File: rtl/lin_byte_rx.sv
module lin_byte_rx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start,
    input  logic             abort,
    input  logic [DIV_W-1:0] div,
    input  logic             rx,
    output logic             done_o,
    output logic [7:0]       data_o
);

    localparam int PW = DIV_W + 1;

    typedef struct packed {
        logic          active;
        logic [PW-1:0] cnt;
        logic [2:0]    idx;
        logic [7:0]    sh;
        logic          done;
    } brx_reg_t;

    brx_reg_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort) begin
            d.active = 1'b0;
        end else if (start) begin
            d.active = 1'b1;
            d.idx    = '0;
            d.cnt    = PW'(div) + PW'(div >> 1) - PW'(1);
        end else if (q.active && tick_en) begin
            if (q.cnt == '0) begin
                d.sh  = {rx, q.sh[7:1]};
                d.idx = q.idx + 3'd1;
                d.cnt = PW'(div) - PW'(1);
                if (q.idx == 3'd7) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end
            end else begin
                d.cnt = q.cnt - PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign data_o = q.sh;

endmodule

// File: rtl/lin_header_top.sv
module lin_header_top
    import lin_hdr_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int DIV_RST     = 16,
    parameter int TX_BRK_BITS = 13,
    parameter int RX_BRK_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             rx_i,
    output logic             tx_o,
    input  logic             master_mode,
    input  logic             brk_req,
    input  logic             div_wr_en,
    input  logic [DIV_W-1:0] div_wr_data,
    output logic [DIV_W-1:0] div_o,
    output logic             tx_busy_o,
    output logic             brk_det_o,
    output logic             hdr_valid_o,
    output logic [7:0]       pid_o,
    output logic             err_delim_o,
    output logic             err_sync_o,
    output logic             err_parity_o
);

    localparam int CNT_W = DIV_W + 4;
    localparam int MW    = DIV_W + 7;

    typedef struct packed {
        hdr_st_e          st;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] run;
        logic [1:0]       falls;
        logic             rx_prev;
        logic [7:0]       pid;
        logic             brk;
        logic             valid;
        logic             e_delim;
        logic             e_sync;
        logic             e_par;
    } hdr_reg_t;

    hdr_reg_t q, d;

    logic             fall, brk_hit, sync_ok;
    logic             rx_start, rx_abort, rx_done;
    logic [7:0]       rx_data;
    logic [CNT_W-1:0] brk_th;
    logic [MW-1:0]    tot, meas;

    lin_break_gen #(
        .DIV_W(DIV_W), .CNT_W(CNT_W), .BITS(TX_BRK_BITS)
    ) u_brk_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .enable(master_mode),
        .req(brk_req), .div(q.div), .tx_o(tx_o), .busy_o(tx_busy_o)
    );

    lin_byte_rx #(
        .DIV_W(DIV_W)
    ) u_byte_rx (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(rx_start),
        .abort(rx_abort), .div(q.div), .rx(rx_i),
        .done_o(rx_done), .data_o(rx_data)
    );

    assign brk_th  = CNT_W'(RX_BRK_BITS) * CNT_W'(q.div);
    assign fall    = tick_en & q.rx_prev & ~rx_i;
    assign brk_hit = tick_en & ~rx_i & (q.low == brk_th - CNT_W'(1));
    // run + 1 gives the edge-to-edge count, + 4 rounds the divide by 8
    assign tot     = MW'(q.run) + MW'(5);
    assign meas    = tot >> SYNC_SHIFT;
    assign sync_ok = (meas * MW'(TOL_DEN) >= MW'(q.div) * MW'(TOL_LO))
                  && (meas * MW'(TOL_DEN) <= MW'(q.div) * MW'(TOL_HI))
                  && ((meas >> DIV_W) == '0);

    always_comb begin
        d         = q;
        d.brk     = brk_hit;
        d.valid   = 1'b0;
        d.e_delim = 1'b0;
        d.e_sync  = 1'b0;
        d.e_par   = 1'b0;
        rx_start  = 1'b0;
        rx_abort  = 1'b0;

        if (tick_en) begin
            d.rx_prev = rx_i;
            if (rx_i)            d.low = '0;
            else if (q.low != '1) d.low = q.low + CNT_W'(1);
        end

        if (master_mode) begin
            d.st     = ST_IDLE;
            rx_abort = 1'b1;
        end else if (brk_hit) begin
            d.st     = ST_DELIM;
            d.run    = '0;
            rx_abort = 1'b1;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_DELIM: if (tick_en) begin
                    if (rx_i) begin
                        d.run = q.run + CNT_W'(1);
                        if (q.run == CNT_W'(q.div) - CNT_W'(1)) d.st = ST_SYNC_WAIT;
                    end else if (q.run != '0) begin
                        d.e_delim = 1'b1;
                        d.st      = ST_IDLE;
                    end
                end
                ST_SYNC_WAIT: if (fall) begin
                    d.run   = '0;
                    d.falls = '0;
                    d.st    = ST_SYNC_MEAS;
                end
                ST_SYNC_MEAS: if (tick_en) begin
                    if (q.run != '1) d.run = q.run + CNT_W'(1);
                    if (fall) begin
                        d.falls = q.falls + 2'd1;
                        if (q.falls == 2'd3) begin
                            if (sync_ok) begin
                                d.div = DIV_W'(meas);
                                d.st  = ST_STOP_WAIT;
                            end else begin
                                d.e_sync = 1'b1;
                                d.st     = ST_IDLE;
                            end
                        end
                    end
                end
                ST_STOP_WAIT: if (tick_en && rx_i) d.st = ST_PID_WAIT;
                ST_PID_WAIT: if (fall) begin
                    rx_start = 1'b1;
                    d.st     = ST_PID_RX;
                end
                ST_PID_RX: if (rx_done) begin
                    d.st = ST_IDLE;
                    if (rx_data[7:6] == id_parity(rx_data[5:0])) begin
                        d.valid = 1'b1;
                        d.pid   = rx_data;
                    end else begin
                        d.e_par = 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end

        if (div_wr_en) d.div = div_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, div: DIV_W'(DIV_RST), rx_prev: 1'b1, default: '0};
        else        q <= d;
    end

    assign div_o        = q.div;
    assign brk_det_o    = q.brk;
    assign hdr_valid_o  = q.valid;
    assign pid_o        = q.pid;
    assign err_delim_o  = q.e_delim;
    assign err_sync_o   = q.e_sync;
    assign err_parity_o = q.e_par;

endmodule

// File: rtl/lin_header_chk.sv
module lin_header_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_mode,
    input logic             brk_req,
    input logic             tx_o,
    input logic             tx_busy_o,
    input logic             div_wr_en,
    input logic [DIV_W-1:0] div_wr_data,
    input logic [DIV_W-1:0] div_o,
    input logic             brk_det_o,
    input logic             hdr_valid_o,
    input logic [7:0]       pid_o,
    input logic             err_delim_o,
    input logic             err_sync_o,
    input logic             err_parity_o
);

    AST_BRK_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode && brk_req && !tx_busy_o && (div_o != '0) |=> !tx_o); // R1

    AST_SLAVE_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode && !tx_busy_o |=> !tx_busy_o); // R1

    AST_BRK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det_o |=> !brk_det_o); // R2

    AST_SYNC_REJECT_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        err_sync_o && !$past(div_wr_en) |-> $stable(div_o)); // R5

    AST_VALID_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> (pid_o[6] == (pid_o[0] ^ pid_o[1] ^ pid_o[2] ^ pid_o[4]))
                     && (pid_o[7] == !(pid_o[1] ^ pid_o[3] ^ pid_o[4] ^ pid_o[5]))); // R7

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_valid_o, err_delim_o, err_sync_o, err_parity_o})); // R8

    AST_DIV_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr_en |=> div_o == $past(div_wr_data)); // R10

    AST_MASTER_NO_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> !$past(master_mode)); // R12

endmodule

bind lin_header_top lin_header_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .brk_req(brk_req),
    .tx_o(tx_o), .tx_busy_o(tx_busy_o), .div_wr_en(div_wr_en),
    .div_wr_data(div_wr_data), .div_o(div_o), .brk_det_o(brk_det_o),
    .hdr_valid_o(hdr_valid_o), .pid_o(pid_o), .err_delim_o(err_delim_o),
    .err_sync_o(err_sync_o), .err_parity_o(err_parity_o)
);

// File: tb/lin_header_top_tb.sv
module lin_header_top_tb;

    localparam int DW  = 8;
    localparam int DR  = 16;
    localparam int BRK = 12 * DR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b1;
    logic          rx = 1'b1;
    logic          tx_o;
    logic          master_mode = 1'b0;
    logic          brk_req = 1'b0;
    logic          div_wr_en = 1'b0;
    logic [DW-1:0] div_wr_data = '0;
    logic [DW-1:0] div_o;
    logic          tx_busy_o, brk_det_o, hdr_valid_o;
    logic [7:0]    pid_o;
    logic          err_delim_o, err_sync_o, err_parity_o;

    int  n_checks = 0;
    int  n_err = 0;
    int  c_brk = 0, c_val = 0, c_dl = 0, c_sy = 0, c_pa = 0;
    int  s_brk, s_val, s_dl, s_sy, s_pa;
    bit  tick_alt = 1'b0;

    always #4 clk = ~clk;

    lin_header_top #(.DIV_W(DW), .DIV_RST(DR)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_i(rx), .tx_o(tx_o),
        .master_mode(master_mode), .brk_req(brk_req), .div_wr_en(div_wr_en),
        .div_wr_data(div_wr_data), .div_o(div_o), .tx_busy_o(tx_busy_o),
        .brk_det_o(brk_det_o), .hdr_valid_o(hdr_valid_o), .pid_o(pid_o),
        .err_delim_o(err_delim_o), .err_sync_o(err_sync_o), .err_parity_o(err_parity_o)
    );

    always @(negedge clk) begin
        tick_en <= tick_alt ? ~tick_en : 1'b1;
        if (rst_n) begin
            if (brk_det_o)    c_brk++;
            if (hdr_valid_o)  c_val++;
            if (err_delim_o)  c_dl++;
            if (err_sync_o)   c_sy++;
            if (err_parity_o) c_pa++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic snap();
        s_brk = c_brk; s_val = c_val; s_dl = c_dl; s_sy = c_sy; s_pa = c_pa;
    endtask

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input int p, input int extra);
        hold(1'b0, p + ((extra > 0) ? 1 : 0));
        for (int i = 0; i < 8; i++) hold(b[i], p + ((i + 1 < extra) ? 1 : 0));
        hold(1'b1, p);
    endtask

    task automatic send_header(input int brk, input int dl, input int p,
                               input int extra, input logic [7:0] pidb, input int ppid);
        hold(1'b0, brk);
        hold(1'b1, dl);
        send_frame(8'h55, p, extra);
        hold(1'b1, p);
        send_frame(pidb, ppid, 0);
        hold(1'b1, 3 * ppid);
    endtask

    task automatic wr_div(input int v);
        div_wr_en = 1'b1;
        div_wr_data = DW'(v);
        @(negedge clk);
        div_wr_en = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] pid_of(input int id);
        logic [5:0] b;
        b = 6'(id);
        return {~(b[1] ^ b[3] ^ b[4] ^ b[5]), b[0] ^ b[1] ^ b[2] ^ b[4], b};
    endfunction

    task automatic measure_break(input bit again, output int lowc);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        lowc = 0;
        while (tx_o == 1'b0 && lowc < 3000) begin
            lowc++;
            brk_req = (again && lowc == 50);
            @(negedge clk);
        end
        brk_req = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int lowc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R10 div reset", int'(div_o), DR);
        chk("R1 tx idle high", int'(tx_o), 1);
        chk("R1 not busy", int'(tx_busy_o), 0);
        chk("R8 no valid at reset", int'(hdr_valid_o), 0);
        hold(1'b1, 40);

        // basic header
        snap();
        send_header(BRK, DR, DR, 0, pid_of(6'h3C), DR);
        chk("R8 one valid", c_val - s_val, 1);
        chk("R6 pid value", int'(pid_o), int'(pid_of(6'h3C)));
        chk("R2 one break", c_brk - s_brk, 1);

        // synch period sweep across the tolerance window
        for (int p = 12; p <= 20; p++) begin
            bit acc;
            wr_div(DR);
            acc = (20 * p >= 17 * DR) && (20 * p <= 23 * DR);
            snap();
            send_header(BRK, DR, p, 0, pid_of(p + 5), p);
            chk("R5 accept valid", c_val - s_val, acc ? 1 : 0);
            chk("R5 reject flag", c_sy - s_sy, acc ? 0 : 1);
            chk("R4 new divider", int'(div_o), acc ? p : DR);
            if (acc) chk("R6 pid at swept rate", int'(pid_o), int'(pid_of(p + 5)));
        end

        // rounding of the synch count
        for (int e = 3; e <= 4; e++) begin
            int expm;
            wr_div(DR);
            expm = (8 * DR + e + 4) / 8;
            snap();
            send_header(BRK, DR, DR, e, pid_of(6'h11), expm);
            chk("R4 rounded divider", int'(div_o), expm);
            chk("R4 rounded valid", c_val - s_val, 1);
        end
        wr_div(DR);

        // every identifier with good and corrupted parity
        for (int id = 0; id < 64; id++) begin
            logic [7:0] good, bad;
            good = pid_of(id);
            bad  = good ^ ((id % 2 == 0) ? 8'h40 : 8'h80);
            snap();
            send_header(BRK, DR, DR, 0, good, DR);
            chk("R7 good parity valid", c_val - s_val, 1);
            chk("R7 good pid", int'(pid_o), int'(good));
            snap();
            send_header(BRK, DR, DR, 0, bad, DR);
            chk("R7 bad parity flagged", c_pa - s_pa, 1);
            chk("R7 bad parity no valid", c_val - s_val, 0);
        end

        // delimiter boundary
        snap();
        send_header(BRK, DR - 1, DR, 0, pid_of(6'h05), DR);
        chk("R3 short delimiter flagged", c_dl - s_dl, 1);
        chk("R3 short delimiter no valid", c_val - s_val, 0);
        snap();
        send_header(BRK, DR, DR, 0, pid_of(6'h05), DR);
        chk("R3 full delimiter ok", c_val - s_val, 1);
        chk("R3 full delimiter no error", c_dl - s_dl, 0);

        // break threshold boundary
        snap();
        hold(1'b0, 11 * DR - 1);
        hold(1'b1, 3 * DR);
        chk("R2 short low no break", c_brk - s_brk, 0);
        snap();
        hold(1'b0, 11 * DR);
        hold(1'b1, 3 * DR);
        chk("R2 threshold low breaks", c_brk - s_brk, 1);

        // break in the middle of the synch field
        snap();
        hold(1'b0, BRK);
        hold(1'b1, DR);
        hold(1'b0, DR); hold(1'b1, DR); hold(1'b0, DR); hold(1'b1, DR); hold(1'b0, DR);
        hold(1'b0, BRK);
        hold(1'b1, DR);
        send_frame(8'h55, DR, 0);
        hold(1'b1, DR);
        send_frame(pid_of(6'h2A), DR, 0);
        hold(1'b1, 3 * DR);
        chk("R9 two breaks", c_brk - s_brk, 2);
        chk("R9 one valid after restart", c_val - s_val, 1);
        chk("R9 no error", (c_dl - s_dl) + (c_sy - s_sy) + (c_pa - s_pa), 0);
        chk("R9 restart pid", int'(pid_o), int'(pid_of(6'h2A)));

        // programmed divider sets the tolerance reference
        wr_div(20);
        chk("R10 written divider", int'(div_o), 20);
        snap();
        send_header(BRK * 2, 20, DR, 0, pid_of(6'h01), DR);
        chk("R5 reject against written divider", c_sy - s_sy, 1);
        chk("R5 divider kept", int'(div_o), 20);
        wr_div(DR);

        // slave mode ignores break requests
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        @(negedge clk);
        chk("R1 slave request ignored tx", int'(tx_o), 1);
        chk("R1 slave request ignored busy", int'(tx_busy_o), 0);

        // master break generation
        master_mode = 1'b1;
        @(negedge clk);
        measure_break(1'b0, lowc);
        chk("R1 break length", lowc, 13 * DR);
        hold(1'b1, 10);
        measure_break(1'b1, lowc);
        chk("R1 request while busy ignored", lowc, 13 * DR);
        hold(1'b1, 10);
        tick_alt = 1'b1;
        @(negedge clk);
        measure_break(1'b0, lowc);
        chk("R11 gated ticks break length", (lowc >= 26 * DR - 1 && lowc <= 26 * DR) ? 1 : 0, 1);
        tick_alt = 1'b0;
        hold(1'b1, 10);

        // master mode: break seen, no header
        snap();
        send_header(BRK, DR, DR, 0, pid_of(6'h07), DR);
        chk("R12 break detected in master", c_brk - s_brk, 1);
        chk("R12 no header in master", c_val - s_val, 0);
        master_mode = 1'b0;
        hold(1'b1, 10);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule